// File: doc/BRIEF.md
# Frame Shift Phase Generator

This block generates the fast four-phase clock pattern that moves a whole charge image out of the light-sensitive section of a frame-transfer sensor and into its shielded store. The same pattern goes to both sections, so every line in both moves one row per shift period. The block is driven from the system clock. A pixel-rate enable sets the pace. Each shift period covers a fixed number of enabled ticks, and within that period each phase is high for a fixed number of ticks. The phases are spaced a quarter period apart.

A controller pulses `start` with the number of rows to move. `busy` goes high on the next clock. When the last shift period has run out, `busy` falls and `done` pulses for one clock. Between transfers the phases rest at the same levels they take on the first tick of a transfer, so the first shift starts without an extra edge. With the default parameters, a full transfer is 1048 rows of 48 ticks each, and each phase is high for 30 ticks, a 5/8 duty cycle.

Top module: `frame_shift_gen`

## Requirements
- R1: After reset, `busy` and `done` are 0 and both phase buses hold the idle pattern 4'b1101. Bit 0 is the first phase, so the first, third and fourth phases are high and the second is low.
- R2: The position within a shift period advances only on clocks where `pix_en` is 1 while busy. A period is 48 such ticks, and with `pix_en` held at 0 the phases and `busy` do not change.
- R3: Let t be the position within the period, from 0 to 47, and k the phase index, from 0 to 3. One clock after the position holds t, phase bit k is 1 exactly when (t + 48 - 12k) mod 48 < 30. Each phase is therefore high for 30 ticks and low for 18.
- R4: Within a period, bit 1 rises at t=12, bit 2 at t=24 and bit 3 at t=36, and bit 0 rises when the next period starts. No two bits ever rise on the same clock.
- R5: `img_ph` and `sto_ph` are equal on every clock.
- R6: An accepted start with count N runs N periods. `busy` falls and `done` is 1 on the clock after the last tick of the last period. `done` is never high for two clocks in a row.
- R7: A `start` that arrives while `busy` is 1 is ignored. It changes neither the end of the running transfer nor its row count.
- R8: A `start` with `line_count` equal to 0 is ignored, and `busy` stays 0.
- R9: Whenever `busy` and `done` are both 0, both phase buses hold 4'b1101.
- R10: A `start` with a non-zero count while idle sets `busy` on the next clock and begins at t=0 of the first row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_en | input | 1 | Pixel-rate tick enable |
| start | input | 1 | Start request, one clock |
| line_count | input | LINE_W (11) | Rows to shift; sampled on an accepted start |
| img_ph | output | PHASES (4) | Image-section phases, bit 0 first |
| sto_ph | output | PHASES (4) | Storage-section phases, bit 0 first |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-clock end-of-transfer pulse |

## Verification
Two cases are hard to reach from the ports. The first is a new start that lands at an awkward moment: mid-period, or right as the last period runs out. The second is a period boundary that falls on a clock where `pix_en` is low. Random stimulus gates `pix_en` at about 75 % and scatters start requests with random counts across busy and idle stretches. Directed runs add a stall with `pix_en` held low and a start issued during a transfer. One complete 1048-row burst checks the exact end cycle.

// File: rtl/fsg_pkg.sv
package fsg_pkg;

  // Level of phase k at position t within a shift period of `step` ticks.
  function automatic logic phase_high(int t, int k, int step, int phases, int high);
    int d;
    d = (t + step - k * (step / phases)) % step;
    return d < high;
  endfunction

  // Rest pattern: the levels every phase holds at position zero.
  function automatic logic [31:0] idle_vec(int step, int phases, int high);
    logic [31:0] v;
    v = '0;
    for (int k = 0; k < phases; k++) v[k] = phase_high(0, k, step, phases, high);
    return v;
  endfunction

endpackage

// File: rtl/fsg_step_timer.sv
module fsg_step_timer #(
  parameter int STEP = 48,
  parameter int T_W  = $clog2(STEP)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr,
  input  logic           adv,
  output logic [T_W-1:0] t,
  output logic           wrap
);
  assign wrap = adv && (t == T_W'(STEP - 1));

  always_ff @(posedge clk) begin
    if (rst || clr)  t <= '0;
    else if (adv)    t <= wrap ? '0 : t + 1'b1;
  end
endmodule

// File: rtl/fsg_line_counter.sv
module fsg_line_counter #(
  parameter int LINE_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [LINE_W-1:0] lines,
  input  logic              step_wrap,
  output logic              last
);
  logic [LINE_W-1:0] rem;

  always_ff @(posedge clk) begin
    if (rst)                          rem <= '0;
    else if (load)                    rem <= lines - 1'b1;
    else if (step_wrap && rem != '0)  rem <= rem - 1'b1;
  end

  assign last = (rem == '0);
endmodule

// File: rtl/fsg_phase_bank.sv
module fsg_phase_bank #(
  parameter int STEP   = 48,
  parameter int HIGH   = 30,
  parameter int PHASES = 4,
  parameter int T_W    = $clog2(STEP)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [T_W-1:0]    t,
  output logic [PHASES-1:0] ph
);
  localparam logic [PHASES-1:0] IDLE_V =
    PHASES'(fsg_pkg::idle_vec(STEP, PHASES, HIGH));

  logic [PHASES-1:0] nxt;

  for (genvar k = 0; k < PHASES; k++) begin : g_ph
    assign nxt[k] = fsg_pkg::phase_high(int'(t), k, STEP, PHASES, HIGH);
  end

  always_ff @(posedge clk) begin
    if (rst) ph <= IDLE_V;
    else     ph <= nxt;
  end
endmodule

// File: rtl/frame_shift_gen.sv
module frame_shift_gen #(
  parameter int STEP_TICKS = 48,
  parameter int HIGH_TICKS = 30,
  parameter int PHASES     = 4,
  parameter int LINE_W     = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pix_en,
  input  logic              start,
  input  logic [LINE_W-1:0] line_count,
  output logic [PHASES-1:0] img_ph,
  output logic [PHASES-1:0] sto_ph,
  output logic              busy,
  output logic              done
);
  localparam int T_W      = $clog2(STEP_TICKS);
  localparam int SECTIONS = 2;

  logic           accept, adv, wrap, last, fin;
  logic [T_W-1:0] pos;
  logic [PHASES-1:0] sec_ph [SECTIONS];

  assign accept = start && !busy && (line_count != '0);
  assign adv    = busy && pix_en;
  assign fin    = wrap && last;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= fin;
      if (accept)   busy <= 1'b1;
      else if (fin) busy <= 1'b0;
    end
  end

  fsg_step_timer #(.STEP(STEP_TICKS), .T_W(T_W)) u_timer (
    .clk(clk), .rst(rst), .clr(accept), .adv(adv), .t(pos), .wrap(wrap)
  );

  fsg_line_counter #(.LINE_W(LINE_W)) u_lines (
    .clk(clk), .rst(rst), .load(accept), .lines(line_count),
    .step_wrap(wrap), .last(last)
  );

  // One registered bank per section so each drives its own loads.
  for (genvar s = 0; s < SECTIONS; s++) begin : g_sec
    fsg_phase_bank #(.STEP(STEP_TICKS), .HIGH(HIGH_TICKS), .PHASES(PHASES), .T_W(T_W)) u_bank (
      .clk(clk), .rst(rst), .t(pos), .ph(sec_ph[s])
    );
  end

  assign img_ph = sec_ph[0];
  assign sto_ph = sec_ph[1];
endmodule

// File: rtl/frame_shift_gen_chk.sv
module frame_shift_gen_chk #(
  parameter int STEP_TICKS = 48,
  parameter int HIGH_TICKS = 30,
  parameter int PHASES     = 4,
  parameter int LINE_W     = 11
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [LINE_W-1:0] line_count,
  input logic [PHASES-1:0] img_ph,
  input logic [PHASES-1:0] sto_ph,
  input logic              busy,
  input logic              done
);
  localparam logic [PHASES-1:0] IDLE_V =
    PHASES'(fsg_pkg::idle_vec(STEP_TICKS, PHASES, HIGH_TICKS));

  p_locked_r5: assert property (@(posedge clk) disable iff (rst)
    img_ph == sto_ph);

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_end_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  p_idle_r9: assert property (@(posedge clk) disable iff (rst)
    (!busy && !done) |-> (img_ph == IDLE_V));

  p_single_rise_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(img_ph & ~$past(img_ph)));

  p_start_r10: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && line_count != '0) |=> busy);

  p_zero_count_r8: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && line_count == '0) |=> !busy);
endmodule

bind frame_shift_gen frame_shift_gen_chk #(
  .STEP_TICKS(STEP_TICKS), .HIGH_TICKS(HIGH_TICKS), .PHASES(PHASES), .LINE_W(LINE_W)
) u_chk (
  .clk(clk), .rst(rst), .start(start), .line_count(line_count),
  .img_ph(img_ph), .sto_ph(sto_ph), .busy(busy), .done(done)
);

// File: tb/frame_shift_gen_test.sv
module frame_shift_gen_test;
  localparam int STEP = 48;
  localparam int HIGH = 30;
  localparam int PH   = 4;
  localparam int LW   = 11;
  localparam logic [PH-1:0] IDLE = 4'b1101;

  logic clk = 1'b0, rst = 1'b1, pix_en = 1'b0, start = 1'b0;
  logic [LW-1:0] lc = '0;
  logic [PH-1:0] img_ph, sto_ph;
  logic busy, done;

  always #2 clk = ~clk;

  frame_shift_gen #(.STEP_TICKS(STEP), .HIGH_TICKS(HIGH), .PHASES(PH), .LINE_W(LW)) uut (
    .clk(clk), .rst(rst), .pix_en(pix_en), .start(start), .line_count(lc),
    .img_ph(img_ph), .sto_ph(sto_ph), .busy(busy), .done(done)
  );

  int checks = 0, errors = 0;
  bit cmp_on = 1'b0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Expected phase pattern at position t (R3).
  function automatic logic [PH-1:0] pat(int t);
    logic [PH-1:0] p;
    for (int k = 0; k < PH; k++) p[k] = ((t + STEP - k * 12) % STEP) < HIGH;
    return p;
  endfunction

  // Reference model built from R2, R3, R6 to R8, R10.
  bit e_busy = 0, e_done = 0;
  int e_t = 0, e_rem = 0;
  logic [PH-1:0] e_ph = IDLE;

  always @(posedge clk) begin
    logic [PH-1:0] nph;
    bit ndone;
    if (rst) begin
      e_busy = 0; e_done = 0; e_t = 0; e_rem = 0; e_ph = IDLE;
    end else begin
      nph = pat(e_t);
      ndone = 0;
      if (!e_busy && start && lc != 0) begin
        e_busy = 1; e_t = 0; e_rem = int'(lc);
      end else if (e_busy && pix_en) begin
        if (e_t == STEP - 1) begin
          e_t = 0; e_rem--;
          if (e_rem == 0) begin e_busy = 0; ndone = 1; end
        end else e_t++;
      end
      e_ph = nph;
      e_done = ndone;
    end
  end

  always @(negedge clk) if (cmp_on) begin
    chk(img_ph == e_ph, "R3", "img_ph", int'(img_ph), int'(e_ph));
    chk(sto_ph == img_ph, "R5", "sto_ph", int'(sto_ph), int'(img_ph));
    chk(busy == e_busy, "R6", "busy", int'(busy), int'(e_busy));
    chk(done == e_done, "R6", "done", int'(done), int'(e_done));
  end

  // Watchdog: an expired run counts as a failed check.
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      chk(1'b0, "WATCHDOG", "cycles", cyc, 190000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int first [PH];
    int done_at;
    logic [PH-1:0] prev;
    void'($urandom(32'd20240611));

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 0 && done == 0, "R1", "busy|done", int'({busy, done}), 0);
    chk(img_ph == IDLE, "R1", "idle img_ph", int'(img_ph), int'(IDLE));
    chk(sto_ph == IDLE, "R1", "idle sto_ph", int'(sto_ph), int'(IDLE));
    cmp_on = 1'b1;

    // R8: zero count is ignored.
    start = 1; lc = 0; pix_en = 1;
    @(negedge clk); start = 0;
    chk(busy == 0, "R8", "busy after zero start", int'(busy), 0);

    // Directed two-row run: R4, R10, R6, R7.
    for (int k = 0; k < PH; k++) first[k] = -1;
    done_at = -1;
    prev = img_ph;
    start = 1; lc = 2; pix_en = 1;
    for (int n = 0; n <= 110; n++) begin
      @(negedge clk);
      start = 0;
      if (n == 0) chk(busy == 1, "R10", "busy after start", int'(busy), 1);
      if (n == 20) begin start = 1; lc = 5; end   // R7: ignored while busy
      for (int k = 0; k < PH; k++)
        if (img_ph[k] && !prev[k] && first[k] < 0) first[k] = n;
      if (done && done_at < 0) done_at = n;
      prev = img_ph;
    end
    chk(first[1] == 13, "R4", "phase 2 rise", first[1], 13);
    chk(first[2] == 25, "R4", "phase 3 rise", first[2], 25);
    chk(first[3] == 37, "R4", "phase 4 rise", first[3], 37);
    chk(first[0] == 49, "R4", "phase 1 rise", first[0], 49);
    chk(done_at == 96, "R7", "done cycle with start while busy", done_at, 96);
    chk(busy == 0, "R6", "busy after end", int'(busy), 0);

    // R9: idle levels hold between transfers.
    for (int n = 0; n < 10; n++) begin
      pix_en = ($urandom_range(0, 1) == 1);
      @(negedge clk);
      chk(img_ph == IDLE && busy == 0, "R9", "idle img_ph", int'(img_ph), int'(IDLE));
    end

    // R2: a stall with pix_en low freezes the transfer.
    pix_en = 0; start = 1; lc = 1;
    @(negedge clk); start = 0;
    repeat (100) @(negedge clk);
    chk(busy == 1, "R2", "busy during stall", int'(busy), 1);
    chk(img_ph == IDLE, "R2", "phases frozen", int'(img_ph), int'(IDLE));
    pix_en = 1;
    repeat (60) @(negedge clk);
    chk(busy == 0, "R2", "busy after release", int'(busy), 0);

    // Random: gated enable, scattered starts with random counts.
    for (int it = 0; it < 25; it++) begin
      start = 1; lc = LW'($urandom_range(0, 4));
      for (int n = 0; n < 420; n++) begin
        @(negedge clk);
        start = ($urandom_range(0, 19) == 0);
        lc = LW'($urandom_range(0, 4));
        pix_en = ($urandom_range(0, 3) != 0);
      end
      start = 0;
    end
    pix_en = 1;
    repeat (500) @(negedge clk);

    // Full burst of 1048 rows at full rate.
    done_at = -1;
    start = 1; lc = 11'd1048; pix_en = 1;
    for (int n = 0; n <= 48 * 1048 + 4; n++) begin
      @(negedge clk);
      start = 0;
      if (done && done_at < 0) done_at = n;
    end
    chk(done_at == 48 * 1048, "R6", "full burst end", done_at, 48 * 1048);
    chk(img_ph == IDLE, "R9", "idle after burst", int'(img_ph), int'(IDLE));

    cmp_on = 1'b0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule